// File: doc/BRIEF.md
# Selectable event LED flasher

This block drives a single indicator LED from a group of eight internal event signals. An 8-bit select mask, written and read back through a simple register port, picks which of the eight signals may light the LED. Each input passes through a two-flop synchronizer, so the sources may be asynchronous to the system clock. When an enabled input goes from low to high, the LED lights for a fixed flash time of 25 ms by default.

The flash time is counted in system clock cycles. The count is computed from a clock-frequency parameter (nominally 106.25 MHz) and a duration parameter in microseconds. A new qualifying edge during a flash restarts the full flash time. Edges that arrive together merge into one flash. A chip that needs two indicators places two instances, and each one keeps its own select mask.

Top module: `event_led_flasher`

## Requirements
- R1: Writing `sel_wdata_i` with `sel_we_i` high updates the select mask at that rising clock edge, and `sel_rdata_o` shows the mask from then on. Without a write the mask holds. Bit k of the mask enables input `evt_i[k]`.
- R2: After reset the select mask reads 0x00 and `led_o` is low.
- R3: A low-to-high change of an enabled input, applied between clock edges, gives its first high `led_o` at the third rising edge after the change. `led_o` then stays high for exactly FLASH_CYCLES = CLK_HZ*FLASH_US/1e6 cycles (25 ms by default).
- R4: A rising edge on an input whose select bit is 0 does not light the LED.
- R5: An enabled input that goes high and stays high gives exactly one flash.
- R6: A qualifying edge during a flash reloads the full flash time, so the LED stays high until FLASH_CYCLES cycles after the new edge is detected.
- R7: Clearing select bits during a flash does not shorten that flash.
- R8: Setting a select bit while its input is already high does not start a flash.
- R9: A high-to-low change of an enabled input does not light the LED.
- R10: Rising edges on several enabled inputs in the same cycle give one flash of FLASH_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_we_i | input | 1 | Select mask write strobe |
| sel_wdata_i | input | 8 | Select mask write data |
| sel_rdata_o | output | 8 | Select mask read data |
| evt_i | input | 8 | Event sources, synchronous or asynchronous |
| led_o | output | 1 | LED drive, high while flashing |

## Verification
The assertions assume that an event input is not toggled within a single clock period more than once. Edges narrower than the synchronizer can capture are outside the contract, and no property claims they are seen. They also assume that the write strobe is synchronous to the clock. The bench changes every input only on the falling clock edge and holds each event level for at least one full cycle. Between scenarios it returns all inputs low and waits until the LED has gone dark.

// File: rtl/led_flash_pkg.sv
package led_flash_pkg;
  function automatic longint flash_cycles(longint clk_hz, longint dur_us);
    return (clk_hz * dur_us) / 64'd1_000_000;
  endfunction
endpackage

// File: rtl/led_sel_reg.sv
module led_sel_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_o <= '0;
    else if (we_i) sel_o <= wdata_i;
  end
endmodule

// File: rtl/led_evt_sync.sv
module led_evt_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh <= '0;
      else         sh <= {sh[STAGES-1:0], evt_i[g]};
    end
    assign rise_o[g] = sh[STAGES-1] & ~sh[STAGES];
  end
endmodule

// File: rtl/led_flash_timer.sv
module led_flash_timer #(
  parameter int             CW   = 4,
  parameter logic [CW-1:0]  LOAD = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  output logic [CW-1:0] cnt_o,
  output logic          led_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_o <= '0;
    else if (trig_i)       cnt_o <= LOAD;
    else if (cnt_o != '0)  cnt_o <= cnt_o - 1'b1;
  end
  assign led_o = (cnt_o != '0);
endmodule

// File: rtl/event_led_flasher.sv
module event_led_flasher
  import led_flash_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 106_250_000,
  parameter int unsigned FLASH_US = 25_000,
  parameter int          N_SRC    = 8,
  parameter int          SYNC_STG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_we_i,
  input  logic [N_SRC-1:0] sel_wdata_i,
  output logic [N_SRC-1:0] sel_rdata_o,
  input  logic [N_SRC-1:0] evt_i,
  output logic             led_o
);
  localparam longint        FLASH_CYC  = flash_cycles(longint'(CLK_HZ), longint'(FLASH_US));
  localparam int            CW         = $clog2(FLASH_CYC + 1);
  localparam logic [CW-1:0] FLASH_LOAD = CW'(FLASH_CYC);

  logic [N_SRC-1:0] sel_q;
  logic [N_SRC-1:0] rise;
  logic             trig;
  logic [CW-1:0]    cnt;

  led_sel_reg #(.W(N_SRC)) u_sel (
    .clk_i, .rst_ni, .we_i(sel_we_i), .wdata_i(sel_wdata_i), .sel_o(sel_q)
  );

  led_evt_sync #(.N(N_SRC), .STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .evt_i, .rise_o(rise)
  );

  assign trig = |(rise & sel_q);

  led_flash_timer #(.CW(CW), .LOAD(FLASH_LOAD)) u_tmr (
    .clk_i, .rst_ni, .trig_i(trig), .cnt_o(cnt), .led_o
  );

  assign sel_rdata_o = sel_q;
endmodule

// File: rtl/event_led_flasher_chk.sv
module event_led_flasher_chk #(
  parameter int            N_SRC = 8,
  parameter int            CW    = 4,
  parameter logic [CW-1:0] LOAD  = '1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_we_i,
  input logic [N_SRC-1:0] sel_wdata_i,
  input logic [N_SRC-1:0] sel_rdata_o,
  input logic             led_o,
  input logic             trig,
  input logic [CW-1:0]    cnt
);
  a_r1_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |=> sel_rdata_o == $past(sel_wdata_i));
  a_r1_mask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we_i |=> $stable(sel_rdata_o));
  a_r3_trigger_lights: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> led_o);
  a_r3_no_spontaneous_flash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(led_o) |-> $past(trig));
  a_r3_flash_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (led_o && cnt != CW'(1)) |=> led_o);
  a_r3_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  a_r6_retrigger_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> cnt == LOAD);
endmodule

bind event_led_flasher event_led_flasher_chk #(
  .N_SRC(N_SRC), .CW(CW), .LOAD(FLASH_LOAD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_we_i(sel_we_i), .sel_wdata_i(sel_wdata_i),
  .sel_rdata_o(sel_rdata_o), .led_o(led_o), .trig(trig), .cnt(cnt)
);

// File: tb/event_led_flasher_test.sv
`timescale 1ns/1ps
module event_led_flasher_test;
  localparam int N = 20;  // 1 MHz * 20 us

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] evt = '0;
  logic       led;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  event_led_flasher #(.CLK_HZ(1_000_000), .FLASH_US(20)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_we_i(we), .sel_wdata_i(wdata),
    .sel_rdata_o(rdata), .evt_i(evt), .led_o(led)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_sel(logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  // sample n falling edges; first = index of first high (0 if none), width = highs
  task automatic observe(int n, output int first, output int width);
    first = 0; width = 0;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      if (led) begin
        width++;
        if (first == 0) first = j;
      end
    end
  endtask

  task automatic settle();
    @(negedge clk); evt = '0;
    repeat (N + 6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R2 mask after reset", int'(rdata), 0);
    chk("R2 led after reset", int'(led), 0);
  endtask

  task automatic t_regs();
    wr_sel(8'hA5);
    chk("R1 readback A5", int'(rdata), 8'hA5);
    repeat (3) @(negedge clk);
    chk("R1 mask holds", int'(rdata), 8'hA5);
    wr_sel(8'h5A);
    chk("R1 readback 5A", int'(rdata), 8'h5A);
  endtask

  task automatic t_basic();
    int f, w;
    wr_sel(8'h01);
    @(negedge clk); evt[0] = 1'b1;
    observe(N + 10, f, w);
    chk("R3 latency", f, 3);
    chk("R3 width", w, N);
    settle();
  endtask

  task automatic t_disabled();
    int f, w;
    wr_sel(8'h0F);
    @(negedge clk); evt[6] = 1'b1;
    observe(N + 10, f, w);
    chk("R4 disabled source", w, 0);
    settle();
  endtask

  task automatic t_held();
    int f, w;
    wr_sel(8'h10);
    @(negedge clk); evt[4] = 1'b1;
    observe(N + 10, f, w);
    chk("R5 first flash width", w, N);
    observe(2 * N, f, w);
    chk("R5 held high no reflash", w, 0);
    settle();
  endtask

  task automatic t_retrigger();
    int f, w;
    wr_sel(8'h03);
    @(negedge clk); evt[0] = 1'b1;
    f = 0; w = 0;
    for (int j = 1; j <= N + 25; j++) begin
      @(negedge clk);
      if (led) begin
        w++;
        if (f == 0) f = j;
      end
      if (j == 10) evt[1] = 1'b1;
    end
    chk("R6 retrigger start", f, 3);
    chk("R6 retrigger width", w, N + 10);
    settle();
  endtask

  task automatic t_clear_mid();
    int f, w;
    wr_sel(8'h04);
    @(negedge clk); evt[2] = 1'b1;
    f = 0; w = 0;
    for (int j = 1; j <= N + 10; j++) begin
      @(negedge clk);
      if (led) begin
        w++;
        if (f == 0) f = j;
      end
      if (j == 5) begin we = 1'b1; wdata = 8'h00; end
      if (j == 6) we = 1'b0;
    end
    chk("R7 mask cleared", int'(rdata), 0);
    chk("R7 flash not cut", w, N);
    settle();
  endtask

  task automatic t_enable_high();
    int f, w;
    wr_sel(8'h00);
    @(negedge clk); evt[3] = 1'b1;
    repeat (5) @(negedge clk);
    wr_sel(8'h08);
    observe(N + 10, f, w);
    chk("R8 enable while high", w, 0);
    settle();
  endtask

  task automatic t_fall();
    int f, w;
    wr_sel(8'h20);
    @(negedge clk); evt[5] = 1'b1;
    observe(N + 10, f, w);
    chk("R9 setup flash", w, N);
    @(negedge clk); evt[5] = 1'b0;
    observe(N + 10, f, w);
    chk("R9 falling edge", w, 0);
    settle();
  endtask

  task automatic t_multi();
    int f, w;
    wr_sel(8'hFF);
    @(negedge clk); evt = 8'hFF;
    observe(N + 10, f, w);
    chk("R10 merged start", f, 3);
    chk("R10 merged width", w, N);
    settle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_disabled();
    t_held();
    t_retrigger();
    t_clear_mid();
    t_enable_high();
    t_fall();
    t_multi();
    finish_run();
  end
endmodule